// File: doc/BRIEF.md
# Self-Test Fault Aggregator and Indicator

This block turns the power-on self-test results of a bank of touch-button channels into one enable mask, and drives one status line per channel. The analog measurement front end supplies its results as digital words, qualified by a single valid strobe. For each channel these are a flag for a short to the supply rail, a 4-bit short-group identifier and a parasitic capacitance in picofarads. A single further word gives the measured value of the shared modulation capacitor.

A start request arms the block and clears earlier results. The first valid strobe after that is evaluated. One cycle later the block publishes the enable mask and raises a done flag. On the next cycle every passing channel drives its status line high and holds it there. At the same moment every failing channel emits one pulse together with the other failing channels. The pulse length is derived from a clock-frequency parameter and is 5 ms by default.

Top module: `post_fault_aggregator`

## Requirements
- R1: A channel whose supply-short flag is 1 is disabled, so its enable_o bit is 0. Enable bit k equals 1 when channel k passes every rule.
- R2: Channel k's short-group identifier is group_id_i[4k+3:4k], and the value 0 means no short. Every channel whose nonzero identifier is also held by at least one other channel is disabled. A nonzero identifier that no other channel holds does not disable its channel.
- R3: When cmod_pf_i is below CMOD_MIN_PF (default 1000) or above CMOD_MAX_PF (default 4000), every channel is disabled. The two boundary values themselves are accepted.
- R4: Channel k's parasitic capacitance is cpar_pf_i[CW*k+CW-1:CW*k]. A channel is disabled when this value exceeds CPAR_MAX_PF (default 40). A value equal to the limit passes.
- R5: start_i clears enable_o, done_o and status_o on the next cycle and arms the block. The first meas_valid_i while armed is captured, and done_o and enable_o appear one cycle later. A meas_valid_i while not armed has no effect.
- R6: Every status_o bit stays 0 while done_o is 0.
- R7: A passing channel's status_o bit rises on the cycle after done_o rises. It then stays high until the next start_i.
- R8: All failing channels' status_o bits rise together on the cycle after done_o rises. They stay high for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 cycles and then return low.
- R9: When start_i and meas_valid_i arrive in the same cycle, the start wins and the strobe is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new evaluation; clears results |
| meas_valid_i | input | 1 | Measurement words are valid this cycle |
| supply_short_i | input | N | Per-channel short-to-supply flag |
| group_id_i | input | N*GW | Per-channel short-group identifier, 0 = none |
| cpar_pf_i | input | N*CW | Per-channel parasitic capacitance, pF |
| cmod_pf_i | input | CW | Modulation capacitor value, pF |
| enable_o | output | N | Per-channel enable mask, 1 = enabled |
| done_o | output | 1 | Evaluation complete |
| status_o | output | N | Per-channel pass/fail indicator |

## Verification
The bench targets the capacitance boundaries 999, 1000, 4000 and 4001 pF and a parasitic value of exactly 40 pF. A design that used the wrong comparison operator would disable channels at these exact limits. Group identifiers cover a lone nonzero value, a pair and a triple. A design that treated any nonzero identifier as a fault would disable the lone channel.

A start request arrives in the same cycle as a strobe, and another arrives in the middle of a pulse. A design that let the strobe through or kept its pulse running would raise done or status_o too early. The pulse length is compared cycle by cycle, so a counter that is off by one shows up at the falling edge.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

  localparam int unsigned GROUP_W = 4;

  // Clock cycles in a pulse of pulse_us microseconds, never fewer than one.
  function automatic int unsigned pulse_cycles(int unsigned clk_hz, int unsigned pulse_us);
    int unsigned c;
    c = (clk_hz / 1000) * pulse_us / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Inclusive window test for a capacitance value.
  function automatic logic cap_in_window(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/pfa_group_short.sv
module pfa_group_short #(
  parameter int unsigned N  = 10,
  parameter int unsigned GW = 4
) (
  input  logic [N*GW-1:0] group_id_i,
  output logic [N-1:0]    shorted_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic peer_hit;
    always_comb begin
      peer_hit = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && group_id_i[j*GW +: GW] == group_id_i[i*GW +: GW]) peer_hit = 1'b1;
      end
    end
    assign shorted_o[i] = (group_id_i[i*GW +: GW] != '0) && peer_hit;
  end
endmodule

// File: rtl/pfa_fault_eval.sv
module pfa_fault_eval
  import pfa_pkg::*;
#(
  parameter int unsigned N           = 10,
  parameter int unsigned CW          = 16,
  parameter int unsigned CMOD_MIN_PF = 1000,
  parameter int unsigned CMOD_MAX_PF = 4000,
  parameter int unsigned CPAR_MAX_PF = 40
) (
  input  logic [N-1:0]    supply_short_i,
  input  logic [N-1:0]    shorted_i,
  input  logic [N*CW-1:0] cpar_pf_i,
  input  logic [CW-1:0]   cmod_pf_i,
  output logic            cmod_ok_o,
  output logic [N-1:0]    pass_o
);
  assign cmod_ok_o = cap_in_window(32'(cmod_pf_i), CMOD_MIN_PF, CMOD_MAX_PF);

  for (genvar k = 0; k < N; k++) begin : g_ch
    logic cpar_ok;
    assign cpar_ok   = cap_in_window(32'(cpar_pf_i[k*CW +: CW]), 0, CPAR_MAX_PF);
    assign pass_o[k] = cmod_ok_o && !supply_short_i[k] && !shorted_i[k] && cpar_ok;
  end
endmodule

// File: rtl/pfa_indicator.sv
module pfa_indicator #(
  parameter int unsigned N         = 10,
  parameter int unsigned PULSE_CYC = 5000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         done_i,
  input  logic [N-1:0] enable_i,
  output logic         launched_o,
  output logic         pulse_o,
  output logic [N-1:0] status_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic             launched_q, pulse_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launched_q <= 1'b0;
      pulse_q    <= 1'b0;
      cnt_q      <= '0;
    end else if (clear_i) begin
      launched_q <= 1'b0;
      pulse_q    <= 1'b0;
      cnt_q      <= '0;
    end else if (done_i && !launched_q) begin
      launched_q <= 1'b1;
      pulse_q    <= 1'b1;
      cnt_q      <= CNT_W'(PULSE_CYC - 1);
    end else if (pulse_q) begin
      if (cnt_q == '0) pulse_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign launched_o = launched_q;
  assign pulse_o    = pulse_q;
  assign status_o   = launched_q ? (enable_i | {N{pulse_q}}) : '0;
endmodule

// File: rtl/post_fault_aggregator.sv
module post_fault_aggregator
  import pfa_pkg::*;
#(
  parameter int unsigned N           = 10,
  parameter int unsigned CW          = 16,
  parameter int unsigned GW          = GROUP_W,
  parameter int unsigned CMOD_MIN_PF = 1000,
  parameter int unsigned CMOD_MAX_PF = 4000,
  parameter int unsigned CPAR_MAX_PF = 40,
  parameter int unsigned CLK_HZ      = 1000000,
  parameter int unsigned PULSE_US    = 5000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            meas_valid_i,
  input  logic [N-1:0]    supply_short_i,
  input  logic [N*GW-1:0] group_id_i,
  input  logic [N*CW-1:0] cpar_pf_i,
  input  logic [CW-1:0]   cmod_pf_i,
  output logic [N-1:0]    enable_o,
  output logic            done_o,
  output logic [N-1:0]    status_o
);
  localparam int unsigned PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_US);

  logic         armed_q, done_q;
  logic [N-1:0] enable_q;
  logic [N-1:0] shorted_w, pass_w;
  logic         cmod_ok_w, accept_w, pulse_w, launched_w;

  pfa_group_short #(.N(N), .GW(GW)) u_group (
    .group_id_i (group_id_i),
    .shorted_o  (shorted_w)
  );

  pfa_fault_eval #(
    .N(N), .CW(CW), .CMOD_MIN_PF(CMOD_MIN_PF), .CMOD_MAX_PF(CMOD_MAX_PF),
    .CPAR_MAX_PF(CPAR_MAX_PF)
  ) u_eval (
    .supply_short_i (supply_short_i),
    .shorted_i      (shorted_w),
    .cpar_pf_i      (cpar_pf_i),
    .cmod_pf_i      (cmod_pf_i),
    .cmod_ok_o      (cmod_ok_w),
    .pass_o         (pass_w)
  );

  // A strobe counts only while armed and not overridden by a start.
  assign accept_w = meas_valid_i && armed_q && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      enable_q <= '0;
    end else if (start_i) begin
      armed_q  <= 1'b1;
      done_q   <= 1'b0;
      enable_q <= '0;
    end else if (accept_w) begin
      armed_q  <= 1'b0;
      done_q   <= 1'b1;
      enable_q <= pass_w;
    end
  end

  pfa_indicator #(.N(N), .PULSE_CYC(PULSE_CYC)) u_ind (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_i),
    .done_i     (done_q),
    .enable_i   (enable_q),
    .launched_o (launched_w),
    .pulse_o    (pulse_w),
    .status_o   (status_o)
  );

  assign enable_o = enable_q;
  assign done_o   = done_q;
endmodule

// File: rtl/pfa_checker.sv
module pfa_checker #(
  parameter int unsigned N           = 10,
  parameter int unsigned CW          = 16,
  parameter int unsigned CMOD_MIN_PF = 1000,
  parameter int unsigned CMOD_MAX_PF = 4000,
  parameter int unsigned PULSE_CYC   = 5000
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         accept,
  input logic [N-1:0] supply_short,
  input logic [CW-1:0] cmod,
  input logic [N-1:0] enable,
  input logic         done,
  input logic [N-1:0] status,
  input logic         pulse_on,
  input logic         launched
);
  localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2);
  logic [RUN_W-1:0] run_q;
  logic             cmod_bad;

  assign cmod_bad = (32'(cmod) < CMOD_MIN_PF) || (32'(cmod) > CMOD_MAX_PF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (pulse_on) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  assert_supply_short_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((enable & $past(supply_short)) == '0));

  assert_cmod_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmod_bad) |=> (enable == '0));

  assert_start_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done && enable == '0 && status == '0));

  assert_mask_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !start_i) |=> $stable(enable));

  assert_quiet_before_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |-> (status == '0));

  assert_pass_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launched |-> ((status & enable) == enable));

  assert_fail_together_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & ~enable) != '0) |-> ((status & ~enable) == ~enable));

  assert_pulse_not_long_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_on |-> (32'(run_q) < PULSE_CYC));

  assert_pulse_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_on) && !$past(start_i)) |-> (32'(run_q) == PULSE_CYC));
endmodule

bind post_fault_aggregator pfa_checker #(
  .N(N), .CW(CW), .CMOD_MIN_PF(CMOD_MIN_PF), .CMOD_MAX_PF(CMOD_MAX_PF),
  .PULSE_CYC(PULSE_CYC)
) u_pfa_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .accept       (accept_w),
  .supply_short (supply_short_i),
  .cmod         (cmod_pf_i),
  .enable       (enable_o),
  .done         (done_o),
  .status       (status_o),
  .pulse_on     (pulse_w),
  .launched     (launched_w)
);

// File: tb/post_fault_aggregator_bench.sv
module post_fault_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 10;
  localparam int CW = 16;
  localparam int GW = 4;
  localparam int CLK_HZ = 4000;
  localparam int PULSE_US = 5000;
  localparam int P = (CLK_HZ / 1000) * PULSE_US / 1000; // 20 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0;
  logic [N-1:0]    sup = '0;
  logic [N*GW-1:0] gid = '0;
  logic [N*CW-1:0] cpar = '0;
  logic [CW-1:0]   cmod = 16'd2200;
  logic [N-1:0]    enable, status;
  logic            done;

  int vectors = 0, miscompares = 0, cyc = 0;
  string tag = "R6";

  // reference model state
  int           m_armed = 0, m_done = 0, m_launched = 0, m_pcnt = 0;
  logic [N-1:0] m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  post_fault_aggregator #(.N(N), .CW(CW), .GW(GW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US))
  u_post_fault_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .meas_valid_i(valid),
    .supply_short_i(sup), .group_id_i(gid), .cpar_pf_i(cpar), .cmod_pf_i(cmod),
    .enable_o(enable), .done_o(done), .status_o(status)
  );

  function automatic logic [N-1:0] ref_mask();
    logic [N-1:0] m;
    bit cmod_good = (int'(cmod) >= 1000) && (int'(cmod) <= 4000);
    for (int k = 0; k < N; k++) begin
      int same = 0;
      for (int j = 0; j < N; j++) if (gid[j*GW +: GW] == gid[k*GW +: GW]) same++;
      m[k] = cmod_good && !sup[k] && (int'(cpar[k*CW +: CW]) <= 40)
             && !(gid[k*GW +: GW] != 0 && same >= 2);
    end
    return m;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (start) begin
        m_armed = 1; m_done = 0; m_en = '0; m_launched = 0; m_pcnt = 0;
      end else begin
        if (m_done == 1 && m_launched == 0) begin m_launched = 1; m_pcnt = P; end
        else if (m_pcnt > 0) m_pcnt--;
        if (m_armed == 1 && valid) begin m_en = ref_mask(); m_done = 1; m_armed = 0; end
      end
    end
    if (cyc > 50000) begin
      miscompares++;
      $display("FAIL watchdog: actual cycle %0d, expected under 50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [N-1:0] exp_st;
    exp_st = (m_launched == 1) ? (m_en | ((m_pcnt > 0) ? ~m_en : '0)) : '0;
    vectors++;
    if (enable !== m_en || done !== (m_done == 1) || status !== exp_st) begin
      miscompares++;
      $display("FAIL %s cycle %0d: actual en=%b done=%b st=%b expected en=%b done=%0d st=%b",
               tag, cyc, enable, done, status, m_en, m_done, exp_st);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_eval(string t, int hold);
    tag = t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    tick(hold);
  endtask

  task automatic clean();
    sup = '0; gid = '0; cpar = '0; cmod = 16'd2200;
    for (int k = 0; k < N; k++) cpar[k*CW +: CW] = 16'd12;
  endtask

  initial begin
    clean();
    tick(3);
    rst_n = 1'b1;
    tag = "R6"; tick(3);
    // strobe with nothing armed is ignored
    tag = "R5"; @(negedge clk); valid = 1'b1; @(negedge clk); valid = 1'b0; tick(4);
    run_eval("R7", P + 6);
    clean(); sup[2] = 1'b1; sup[9] = 1'b1; run_eval("R1", P + 4);
    clean();
    gid[0*GW +: GW] = 4'd3; gid[5*GW +: GW] = 4'd3; gid[7*GW +: GW] = 4'd9;
    gid[1*GW +: GW] = 4'd4; gid[2*GW +: GW] = 4'd4; gid[3*GW +: GW] = 4'd4;
    run_eval("R2", P + 4);
    clean(); cpar[4*CW +: CW] = 16'd41; cpar[6*CW +: CW] = 16'd40; run_eval("R4", P + 4);
    clean(); cmod = 16'd999;  run_eval("R3", P + 3);
    cmod = 16'd1000; run_eval("R3", 4);
    cmod = 16'd4000; run_eval("R3", 4);
    cmod = 16'd4001; run_eval("R3", P + 3);
    // start and strobe together: start wins, next strobe is captured
    clean(); sup[0] = 1'b1; tag = "R9";
    @(negedge clk); start = 1'b1; valid = 1'b1;
    @(negedge clk); start = 1'b0; valid = 1'b0; tick(3);
    @(negedge clk); valid = 1'b1; @(negedge clk); valid = 1'b0;
    tag = "R8"; tick(P + 5);
    // restart in the middle of a pulse
    sup[5] = 1'b1; run_eval("R8", P / 2);
    tag = "R5"; @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; tick(P + 3);
    @(negedge clk); valid = 1'b1; @(negedge clk); valid = 1'b0; tag = "R8"; tick(P + 5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule